// File: doc/BRIEF.md
# Settable 12-Hour Time-of-Day Counter

This block keeps hours, minutes and seconds in a 12-hour format. All of its state sits on one system clock. A free-running binary divider sets the time base. The rising edge of the divider's top bit is found by comparing that bit with a registered copy of itself, and it gives a one-cycle second tick. Seconds count 0 to 59. Minutes take a carry when seconds roll over, and hours take a carry when both minutes and seconds roll over. Hours run from 1 to 12.

Two pulse inputs let the user set the clock by hand. One advances the minute field and the other advances the hour field, while seconds keep running. Both pulses are sampled as synchronous enables on the system clock. For every field the block gives out the binary count and a fourteen-bit, two-digit seven-segment pattern. There is no data stream, so the block has no valid/ready interface. The set inputs are plain single-cycle pulses that are assumed to be already debounced, and the outputs are plain registered levels.

Top module: `hms12_clock`

## Requirements
- R1: The seconds field counts 0 to 59, moving by one on each tick and going from 59 back to 0. It does not change in a cycle with no tick.
- R2: The divider has DIV_W bits and clears on reset. The first tick is seen by the counters 2^(DIV_W-1)+1 clock edges after reset is released, and ticks then repeat every 2^DIV_W edges. A tick never lasts two cycles in a row.
- R3: The minute field advances by one on a tick when seconds are 59, and it goes from 59 back to 0.
- R4: The hour field advances on a tick only when minutes and seconds are both 59. It goes from 12 back to 1 and always stays between 1 and 12.
- R5: A pulse on `min_step` adds one to the minute field on the next edge. At 59 it wraps to 0 and leaves the hour field unchanged.
- R6: A pulse on `hour_step` adds one to the hour field on the next edge. At 12 it wraps to 1.
- R7: If a set pulse and a natural carry reach the same field in the same cycle, that field advances only once.
- R8: While `rst` is high on a clock edge, the block shows 1:00:00 and the divider clears.
- R9: Each segment output holds the tens digit in bits 13:7 and the units digit in bits 6:0. Each digit is a 7-bit pattern with segment g in the top bit and a in the low bit: 0=0111111, 1=0000110, 2=1011011, 3=1001111, 4=1100110, 5=1101101, 6=1111101, 7=0000111, 8=1111111, 9=1101111. Hours below 10 show a leading 0.
- R10: Set pulses have no effect on the seconds field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| min_step | input | 1 | Single-cycle pulse that advances minutes |
| hour_step | input | 1 | Single-cycle pulse that advances hours |
| sec_bin | output | 6 | Seconds, binary 0..59 |
| min_bin | output | 6 | Minutes, binary 0..59 |
| hr_bin | output | 4 | Hours, binary 1..12 |
| sec_seg | output | 14 | Seconds, two-digit segment pattern |
| min_seg | output | 14 | Minutes, two-digit segment pattern |
| hr_seg | output | 14 | Hours, two-digit segment pattern |

## Verification
A set pulse applied before an edge appears on the binary and segment outputs right after that edge, one cycle of latency. A tick reaches the counters one edge after the divider's top bit rises, so seconds change 2^(DIV_W-1)+1 edges after reset and every 2^DIV_W edges after that. The bench keeps an edge count and a time model that it updates on every rising edge. It compares all six outputs at each falling edge, so every result is checked exactly in the cycle it is due. Directed stimuli aim a set pulse at the exact cycle a carry is pending, and they drive the clock across 12:59:59.

// File: rtl/hms12_pkg.sv
package hms12_pkg;
  localparam int SEC_W = 6;
  localparam int MIN_W = 6;
  localparam int HR_W  = 4;
  localparam int SEG_W = 7;
  localparam int DISP_W = 2 * SEG_W;
  localparam int LAST_SM = 59;
  localparam int LAST_HR = 12;

  function automatic logic [SEG_W-1:0] digit_seg(input logic [3:0] d);
    logic [SEG_W-1:0] s;
    case (d)
      4'd0: s = 7'b0111111;
      4'd1: s = 7'b0000110;
      4'd2: s = 7'b1011011;
      4'd3: s = 7'b1001111;
      4'd4: s = 7'b1100110;
      4'd5: s = 7'b1101101;
      4'd6: s = 7'b1111101;
      4'd7: s = 7'b0000111;
      4'd8: s = 7'b1111111;
      4'd9: s = 7'b1101111;
      default: s = 7'b0000000;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/hms12_tick.sv
module hms12_tick #(
  parameter int DIV_W = 25
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int TOP = DIV_W - 1;

  logic [DIV_W-1:0] div_q;
  logic             top_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      top_q <= 1'b0;
    end else begin
      div_q <= div_q + 1'b1;
      top_q <= div_q[TOP];
    end
  end

  assign tick = div_q[TOP] & ~top_q;

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/hms12_core.sv
module hms12_core
  import hms12_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             min_step,
  input  logic             hour_step,
  output logic [SEC_W-1:0] sec_q,
  output logic [MIN_W-1:0] min_q,
  output logic [HR_W-1:0]  hr_q
);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(LAST_SM);
  localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(LAST_SM);
  localparam logic [HR_W-1:0]  HR_LAST  = HR_W'(LAST_HR);

  logic sec_wrap, min_carry, hr_carry, min_adv, hr_adv;

  assign sec_wrap  = tick && (sec_q == SEC_LAST);
  assign min_carry = sec_wrap;
  assign hr_carry  = sec_wrap && (min_q == MIN_LAST);
  // a set pulse and a carry in the same cycle merge into one advance
  assign min_adv   = min_step | min_carry;
  assign hr_adv    = hour_step | hr_carry;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= HR_W'(1);
    end else begin
      if (tick)
        sec_q <= sec_wrap ? '0 : sec_q + 1'b1;
      if (min_adv)
        min_q <= (min_q == MIN_LAST) ? '0 : min_q + 1'b1;
      if (hr_adv)
        hr_q <= (hr_q == HR_LAST) ? HR_W'(1) : hr_q + 1'b1;
    end
  end

  assert_sec_range_R1: assert property (@(posedge clk) disable iff (rst)
    sec_q <= SEC_LAST);
  assert_sec_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sec_q));
  assert_hr_range_R4: assert property (@(posedge clk) disable iff (rst)
    (hr_q >= HR_W'(1)) && (hr_q <= HR_LAST));
  assert_min_step_R5: assert property (@(posedge clk) disable iff (rst)
    (min_step && min_q == MIN_LAST && !hour_step && !hr_carry) |=>
      (min_q == '0) && $stable(hr_q));
  assert_hr_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (hour_step && hr_q == HR_LAST) |=> hr_q == HR_W'(1));
  assert_once_R7: assert property (@(posedge clk) disable iff (rst)
    (min_step && sec_wrap && min_q < MIN_W'(58)) |=> min_q == $past(min_q) + 1'b1);
endmodule

// File: rtl/hms12_seg.sv
module hms12_seg
  import hms12_pkg::*;
#(
  parameter int VW = 6
) (
  input  logic [VW-1:0]     val,
  output logic [DISP_W-1:0] seg
);
  logic [6:0] wide, tens, units;

  always_comb begin
    wide  = 7'(val);
    tens  = wide / 7'd10;
    units = wide - tens * 7'd10;
    seg   = {digit_seg(tens[3:0]), digit_seg(units[3:0])};
  end

  always_comb begin
    if (wide < 7'd100)
      assert_units_lit_R9: assert (seg[SEG_W-1:0] != '0);
  end
endmodule

// File: rtl/hms12_clock.sv
module hms12_clock
  import hms12_pkg::*;
#(
  parameter int DIV_W = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              min_step,
  input  logic              hour_step,
  output logic [SEC_W-1:0]  sec_bin,
  output logic [MIN_W-1:0]  min_bin,
  output logic [HR_W-1:0]   hr_bin,
  output logic [DISP_W-1:0] sec_seg,
  output logic [DISP_W-1:0] min_seg,
  output logic [DISP_W-1:0] hr_seg
);
  logic tick;

  hms12_tick #(.DIV_W(DIV_W)) tick_i (.clk(clk), .rst(rst), .tick(tick));

  hms12_core core_i (
    .clk(clk), .rst(rst), .tick(tick),
    .min_step(min_step), .hour_step(hour_step),
    .sec_q(sec_bin), .min_q(min_bin), .hr_q(hr_bin)
  );

  hms12_seg #(.VW(SEC_W)) seg_s_i (.val(sec_bin), .seg(sec_seg));
  hms12_seg #(.VW(MIN_W)) seg_m_i (.val(min_bin), .seg(min_seg));
  hms12_seg #(.VW(HR_W))  seg_h_i (.val(hr_bin),  .seg(hr_seg));
endmodule

// File: tb/hms12_clock_tb.sv
module hms12_clock_tb_top;
  localparam int DIV_W = 3;
  localparam int PER = 1 << DIV_W;
  localparam int HALF = PER / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic min_step = 1'b0;
  logic hour_step = 1'b0;
  logic [5:0] sec_bin, min_bin;
  logic [3:0] hr_bin;
  logic [13:0] sec_seg, min_seg, hr_seg;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit started = 0;
  int m_s = 0, m_m = 0, m_h = 1, m_cnt = 0;

  always #2 clk = ~clk;

  hms12_clock #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst(rst), .min_step(min_step), .hour_step(hour_step),
    .sec_bin(sec_bin), .min_bin(min_bin), .hr_bin(hr_bin),
    .sec_seg(sec_seg), .min_seg(min_seg), .hr_seg(hr_seg)
  );

  function automatic logic [6:0] pat(input int d);
    case (d)
      0: return 7'b0111111; 1: return 7'b0000110; 2: return 7'b1011011;
      3: return 7'b1001111; 4: return 7'b1100110; 5: return 7'b1101101;
      6: return 7'b1111101; 7: return 7'b0000111; 8: return 7'b1111111;
      default: return 7'b1101111;
    endcase
  endfunction

  function automatic logic [13:0] disp(input int v);
    return {pat(v / 10), pat(v % 10)};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    bit tk, cs, ch;
    started = 1;
    if (rst) begin
      m_s = 0; m_m = 0; m_h = 1; m_cnt = 0;
    end else begin
      tk = (m_cnt % PER) == HALF;
      cs = tk && m_s == 59;
      ch = cs && m_m == 59;
      if (tk) m_s = (m_s == 59) ? 0 : m_s + 1;
      if (min_step || cs) m_m = (m_m == 59) ? 0 : m_m + 1;
      if (hour_step || ch) m_h = (m_h == 12) ? 1 : m_h + 1;
      m_cnt++;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R1/R10 sec_bin", int'(sec_bin), m_s);
      chk("R3/R5 min_bin", int'(min_bin), m_m);
      chk("R4/R6 hr_bin", int'(hr_bin), m_h);
      chk("R9 sec_seg", int'(sec_seg), int'(disp(m_s)));
      chk("R9 min_seg", int'(min_seg), int'(disp(m_m)));
      chk("R9 hr_seg", int'(hr_seg), int'(disp(m_h)));
    end
  end

  task automatic pulse_min();
    @(negedge clk) min_step = 1'b1;
    @(negedge clk) min_step = 1'b0;
  endtask

  task automatic pulse_hr();
    @(negedge clk) hour_step = 1'b1;
    @(negedge clk) hour_step = 1'b0;
  endtask

  task automatic wait_carry_pending();
    @(negedge clk);
    while (!(m_s == 59 && (m_cnt % PER) == HALF)) @(negedge clk);
  endtask

  initial begin
    int s_before;
    repeat (3) @(negedge clk);
    chk("R8 reset hr", int'(hr_bin), 1);
    chk("R8 reset min", int'(min_bin), 0);
    chk("R8 reset sec", int'(sec_bin), 0);
    chk("R9 reset hr_seg", int'(hr_seg), int'({7'b0111111, 7'b0000110}));
    rst = 1'b0;
    // R2: first change after HALF+1 edges
    repeat (HALF) @(negedge clk);
    chk("R2 sec before first tick", int'(sec_bin), 0);
    @(negedge clk);
    chk("R2 sec after first tick", int'(sec_bin), 1);
    repeat (PER - 1) @(negedge clk);
    chk("R2 sec before second tick", int'(sec_bin), 1);
    @(negedge clk);
    chk("R2 sec after second tick", int'(sec_bin), 2);
    // R6: hour set and wrap
    repeat (11) pulse_hr();
    chk("R6 hour set to 12", int'(hr_bin), 12);
    chk("R9 hr_seg 12", int'(hr_seg), int'({7'b0000110, 7'b1011011}));
    pulse_hr();
    chk("R6 hour wrap 12->1", int'(hr_bin), 1);
    repeat (11) pulse_hr();
    // R10: a set pulse in a no-tick cycle leaves seconds alone
    @(negedge clk);
    while ((m_cnt % PER) == HALF) @(negedge clk);
    s_before = int'(sec_bin);
    hour_step = 1'b1;
    @(negedge clk) hour_step = 1'b0;
    chk("R10 sec unchanged by set", int'(sec_bin), s_before);
    pulse_hr(); pulse_hr(); pulse_hr(); pulse_hr();
    pulse_hr(); pulse_hr(); pulse_hr(); pulse_hr();
    pulse_hr(); pulse_hr(); pulse_hr();
    chk("R6 back at 12", int'(hr_bin), 12);
    // R5: minute wrap without hour carry
    while (m_m != 59) pulse_min();
    chk("R5 minute at 59", int'(min_bin), 59);
    pulse_min();
    chk("R5 minute wrap to 0", int'(min_bin), 0);
    chk("R5 no hour carry", int'(hr_bin), 12);
    // R7: set pulse coincident with natural carry
    while (m_m != 10) pulse_min();
    wait_carry_pending();
    min_step = 1'b1;
    @(negedge clk) min_step = 1'b0;
    chk("R7 single advance", int'(min_bin), 11);
    chk("R3 sec wrapped", int'(sec_bin), 0);
    // R4/R3: roll over 12:59:59
    while (m_m != 59) pulse_min();
    wait_carry_pending();
    @(negedge clk);
    chk("R4 hour 12->1", int'(hr_bin), 1);
    chk("R3 minute 59->0", int'(min_bin), 0);
    chk("R1 sec 59->0", int'(sec_bin), 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule